// File: doc/BRIEF.md
# Sparse Bitmap-Indexed Feature Aggregator

This block computes, for one destination vertex of a graph network layer, the weighted sum of its neighbours' feature slices. Each neighbour slice arrives in a compressed layout made of 64-byte lines. The first line begins with an occupancy bitmap of the slice positions. The non-zero values follow it, packed and in ascending position order, and they continue into further lines when they do not fit in the first one. For each neighbour the engine first takes one scalar edge weight. It then takes the lines of that neighbour's slice and multiplies all sixteen line words by the weight in parallel. A prefix count over the bitmap routes each product to its dense accumulator slot.

The engine reads a further line of a neighbour only while the number of ones in the bitmap is larger than the number of values already delivered. A weight marked as the last one closes the vertex. After the final line of that neighbour, the dense accumulated slice is offered on a result stream. A start pulse clears the accumulators before a new vertex. Address generation, the memory system and the combination stage that consumes the result belong to other blocks.

Top module: `sparseAggEngine`

## Requirements
- R1: After reset, `resValid` and `lineReady` are low, `weightReady` is high, and every accumulator slot on `resData` reads zero.
- R2: In the first line of a neighbour, words 0 to ceil(SLICE_W/32)-1 hold the bitmap, and bit p of `lineData` marks slice position p as non-zero. The packed values start at the next word. The k-th packed value, counting from 0 in ascending position order, belongs to the k-th set bit. Unused trailing words are ignored.
- R3: Every packed value v of a neighbour with weight w adds bits [FRAC_BITS+31:FRAC_BITS] of the 64-bit signed product v*w to slot p. This is the arithmetic right shift of the product by FRAC_BITS, truncated to 32 bits. Slot p sits at `resData[32*p +: 32]`.
- R4: A slot whose bitmap bit is 0 keeps its value, whatever the line words hold.
- R5: The first line carries 16-ceil(SLICE_W/32) values and each further line carries 16. The engine accepts another line of the same neighbour only while the bitmap's ones count exceeds the values delivered so far. With SLICE_W=32, 15 ones take one line, 16 ones take two lines and 32 ones take three.
- R6: A neighbour whose bitmap is all zeros consumes exactly one line and changes no slot.
- R7: After the last line of a neighbour whose weight had `weightLast` set, `resValid` rises on the next cycle. While `resReady` is low, `resValid` and `resData` stay unchanged.
- R8: A `startVertex` pulse zeroes every slot unless a result is pending, in which case it is ignored. When it coincides with an accepted line, that line's products are added onto zero.
- R9: The handshakes run in a fixed order: one weight (`weightReady` high, nothing else), then that neighbour's lines (`lineReady` high), then either the next weight or the result. At most one of `weightReady`, `lineReady` and `resValid` is high at a time, so lines stall while the result is back-pressured.
- R10: Accumulation wraps modulo 2^32. Two additions of 0x7FFFFFFF give 0xFFFFFFFE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| startVertex | input | 1 | Pulse that clears the accumulators before a new vertex |
| weightValid | input | 1 | Edge weight offered |
| weightReady | output | 1 | Engine accepts an edge weight |
| weightData | input | DATA_W | Signed fixed-point edge weight |
| weightLast | input | 1 | This weight belongs to the last neighbour of the vertex |
| lineValid | input | 1 | Slice line offered |
| lineReady | output | 1 | Engine accepts a slice line |
| lineData | input | LANES*DATA_W | 64-byte line, word i at bits [32*i +: 32] |
| resValid | output | 1 | Dense result slice offered |
| resReady | input | 1 | Consumer accepts the result |
| resData | output | SLICE_W*DATA_W | Dense accumulated slice |

## Verification
A mistake in the prefix routing or in the line-count state shows up at once in `resData` or in the ready outputs. The wrong slot moves in the same cycle its line is accepted. A wrong continuation decision lowers or keeps `lineReady` one cycle after the line it concerns. Because of this, the reference model is compared on every clock against the ready flags and all slots, and does not wait for the end of a vertex. The directed slices aim at the boundaries where such faults live. These are exactly 15 and 16 ones, a full bitmap, an empty bitmap, junk in unused words, negative weights whose shift must round downward, overflow, and a clear that coincides with a line.

// File: rtl/sparseAggPkg.sv
package sparseAggPkg;

  typedef enum logic [1:0] {
    ST_WEIGHT,
    ST_HEAD,
    ST_BODY,
    ST_OUT
  } aggState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadWeight;
    logic headFire;
    logic bodyFire;
    logic clearAcc;
  } aggStrobe_t;

endpackage

// File: rtl/sparseAggPrefix.sv
module sparseAggPrefix #(
  parameter int SLICE_W = 32,
  localparam int CNT_W = $clog2(SLICE_W + 1)
) (
  input  logic [SLICE_W-1:0]            occBits,
  output logic [SLICE_W-1:0][CNT_W-1:0] rankOut,
  output logic [CNT_W-1:0]              onesTotal
);

  // each position counts the set bits strictly below it, all in parallel
  for (genvar p = 0; p < SLICE_W; p++) begin : g_rank
    localparam logic [SLICE_W-1:0] LOW_MASK = (SLICE_W'(1) << p) - SLICE_W'(1);
    assign rankOut[p] = CNT_W'($countones(occBits & LOW_MASK));
  end

  assign onesTotal = CNT_W'($countones(occBits));

endmodule

// File: rtl/sparseAggCtrl.sv
module sparseAggCtrl
  import sparseAggPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startVertex,
  input  logic       weightValid,
  input  logic       weightLast,
  input  logic       lineValid,
  input  logic       resReady,
  input  logic       needMore,
  output logic       weightReady,
  output logic       lineReady,
  output logic       resValid,
  output aggStrobe_t strobe
);

  aggState_t state, stateNext;
  logic      lastReg;

  assign weightReady = (state == ST_WEIGHT);
  assign lineReady   = (state == ST_HEAD) || (state == ST_BODY);
  assign resValid    = (state == ST_OUT);

  always_comb begin
    strobe.loadWeight = weightValid && weightReady;
    strobe.headFire   = lineValid && (state == ST_HEAD);
    strobe.bodyFire   = lineValid && (state == ST_BODY);
    strobe.clearAcc   = startVertex && (state != ST_OUT);
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_WEIGHT: if (weightValid) stateNext = ST_HEAD;
      ST_HEAD, ST_BODY:
        if (lineValid) begin
          if (needMore)     stateNext = ST_BODY;
          else if (lastReg) stateNext = ST_OUT;
          else              stateNext = ST_WEIGHT;
        end
      ST_OUT:    if (resReady) stateNext = ST_WEIGHT;
      default:   stateNext = ST_WEIGHT;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_WEIGHT;
      lastReg <= 1'b0;
    end else begin
      state <= stateNext;
      if (strobe.loadWeight) lastReg <= weightLast;
    end
  end

endmodule

// File: rtl/sparseAggDatapath.sv
module sparseAggDatapath
  import sparseAggPkg::*;
#(
  parameter int SLICE_W   = 32,
  parameter int DATA_W    = 32,
  parameter int LANES     = 16,
  parameter int FRAC_BITS = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  aggStrobe_t                strobe,
  input  logic [DATA_W-1:0]         weightData,
  input  logic [LANES*DATA_W-1:0]   lineData,
  output logic                      needMore,
  output logic [SLICE_W*DATA_W-1:0] resData
);

  localparam int BMAP_WORDS = (SLICE_W + DATA_W - 1) / DATA_W;
  localparam int HEAD_VALS  = LANES - BMAP_WORDS;
  localparam int CNT_W      = $clog2(SLICE_W + 1);
  localparam int USED_W     = $clog2(SLICE_W + 2 * LANES + 1) + 1;
  localparam int LANE_IW    = $clog2(LANES);

  logic [DATA_W-1:0]                weightReg;
  logic [SLICE_W-1:0]               bitmapReg;
  logic [USED_W-1:0]                usedReg;
  logic [SLICE_W-1:0][DATA_W-1:0]   acc, accNext;
  logic [LANES-1:0][DATA_W-1:0]     prod;
  logic [SLICE_W-1:0]               curBitmap;
  logic [SLICE_W-1:0][CNT_W-1:0]    rank;
  logic [CNT_W-1:0]                 curTotal;
  logic [USED_W-1:0]                base, avail, offset, usedNext;
  logic                             lineFire;

  // broadcast multiply, shift by fraction bits, keep DATA_W bits
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic signed [2*DATA_W-1:0] full;
    assign full    = $signed(lineData[l*DATA_W +: DATA_W]) * $signed(weightReg);
    assign prod[l] = full[FRAC_BITS +: DATA_W];
  end

  assign lineFire  = strobe.headFire || strobe.bodyFire;
  assign curBitmap = strobe.headFire ? lineData[SLICE_W-1:0] : bitmapReg;

  sparseAggPrefix #(.SLICE_W(SLICE_W)) i_prefix (
    .occBits   (curBitmap),
    .rankOut   (rank),
    .onesTotal (curTotal)
  );

  assign base     = strobe.headFire ? '0 : usedReg;
  assign avail    = strobe.headFire ? USED_W'(HEAD_VALS) : USED_W'(LANES);
  assign offset   = strobe.headFire ? USED_W'(BMAP_WORDS) : '0;
  assign usedNext = base + avail;
  assign needMore = USED_W'(curTotal) > usedNext;

  always_comb begin
    for (int p = 0; p < SLICE_W; p++) begin
      accNext[p] = strobe.clearAcc ? '0 : acc[p];
      if (lineFire && curBitmap[p] &&
          USED_W'(rank[p]) >= base && USED_W'(rank[p]) < usedNext) begin
        accNext[p] = accNext[p] + prod[LANE_IW'(USED_W'(rank[p]) - base + offset)];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      weightReg <= '0;
      bitmapReg <= '0;
      usedReg   <= '0;
      acc       <= '0;
    end else begin
      if (strobe.loadWeight) weightReg <= weightData;
      if (strobe.headFire)   bitmapReg <= lineData[SLICE_W-1:0];
      if (lineFire)          usedReg   <= usedNext;
      acc <= accNext;
    end
  end

  assign resData = acc;

endmodule

// File: rtl/sparseAggEngine.sv
module sparseAggEngine
  import sparseAggPkg::*;
#(
  parameter int SLICE_W   = 32,
  parameter int DATA_W    = 32,
  parameter int LANES     = 16,
  parameter int FRAC_BITS = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      startVertex,
  input  logic                      weightValid,
  output logic                      weightReady,
  input  logic [DATA_W-1:0]         weightData,
  input  logic                      weightLast,
  input  logic                      lineValid,
  output logic                      lineReady,
  input  logic [LANES*DATA_W-1:0]   lineData,
  output logic                      resValid,
  input  logic                      resReady,
  output logic [SLICE_W*DATA_W-1:0] resData
);

  aggStrobe_t strobe;
  logic       needMore;

  sparseAggCtrl i_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .startVertex (startVertex),
    .weightValid (weightValid),
    .weightLast  (weightLast),
    .lineValid   (lineValid),
    .resReady    (resReady),
    .needMore    (needMore),
    .weightReady (weightReady),
    .lineReady   (lineReady),
    .resValid    (resValid),
    .strobe      (strobe)
  );

  sparseAggDatapath #(
    .SLICE_W   (SLICE_W),
    .DATA_W    (DATA_W),
    .LANES     (LANES),
    .FRAC_BITS (FRAC_BITS)
  ) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .weightData (weightData),
    .lineData   (lineData),
    .needMore   (needMore),
    .resData    (resData)
  );

endmodule

// File: rtl/sparseAggChecker.sv
module sparseAggChecker #(
  parameter int SLICE_W = 32,
  parameter int DATA_W  = 32
) (
  input logic                      clk,
  input logic                      rstN,
  input logic                      startVertex,
  input logic                      weightValid,
  input logic                      weightReady,
  input logic                      lineValid,
  input logic                      lineReady,
  input logic                      resValid,
  input logic                      resReady,
  input logic [SLICE_W*DATA_W-1:0] resData
);

  // R9: the three channel flags are mutually exclusive
  assert_flags_exclusive_R9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({weightReady, lineReady, resValid}));

  // R9: an accepted weight opens the line phase
  assert_lines_after_weight_R9: assert property (@(posedge clk) disable iff (!rstN)
    weightValid && weightReady |=> lineReady);

  // R7: a stalled result holds
  assert_result_held_R7: assert property (@(posedge clk) disable iff (!rstN)
    resValid && !resReady |=> resValid && $stable(resData));

  // R7: a taken result returns to the weight phase
  assert_result_release_R7: assert property (@(posedge clk) disable iff (!rstN)
    resValid && resReady |=> weightReady);

  // R8: a clear with no line and no pending result zeroes the slice
  assert_start_clears_R8: assert property (@(posedge clk) disable iff (!rstN)
    startVertex && !resValid && !(lineValid && lineReady) |=> resData == '0);

endmodule

bind sparseAggEngine sparseAggChecker #(.SLICE_W(SLICE_W), .DATA_W(DATA_W)) i_chk (
  .clk         (clk),
  .rstN        (rstN),
  .startVertex (startVertex),
  .weightValid (weightValid),
  .weightReady (weightReady),
  .lineValid   (lineValid),
  .lineReady   (lineReady),
  .resValid    (resValid),
  .resReady    (resReady),
  .resData     (resData)
);

// File: tb/test_sparseAggEngine.sv
module test_sparseAggEngine;

  localparam int C     = 32;
  localparam int DW    = 32;
  localparam int LN    = 16;
  localparam int FRAC  = 8;
  localparam int BMW   = 1;
  localparam int HEADV = LN - BMW;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              startVertex = 1'b0;
  logic              weightValid = 1'b0;
  logic              weightReady;
  logic [DW-1:0]     weightData = '0;
  logic              weightLast = 1'b0;
  logic              lineValid = 1'b0;
  logic              lineReady;
  logic [LN*DW-1:0]  lineData = '0;
  logic              resValid;
  logic              resReady = 1'b0;
  logic [C*DW-1:0]   resData;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  sparseAggEngine #(.SLICE_W(C), .DATA_W(DW), .LANES(LN), .FRAC_BITS(FRAC)) i_sparseAggEngine (
    .clk(clk), .rstN(rstN), .startVertex(startVertex),
    .weightValid(weightValid), .weightReady(weightReady), .weightData(weightData),
    .weightLast(weightLast), .lineValid(lineValid), .lineReady(lineReady),
    .lineData(lineData), .resValid(resValid), .resReady(resReady), .resData(resData)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int slotOf(input int p);
    return int'($signed(resData[p*DW +: DW]));
  endfunction

  // ---------------- behavioural reference model ----------------
  int mState = 0;   // 0 weight, 1 head, 2 body, 3 out
  int mAcc[C];
  int mWeight = 0;
  bit mLast = 1'b0;
  int posQ[$];
  int ptr = 0;
  bit modelLive = 1'b0;

  function automatic int scaled(input int v, input int w);
    longint full;
    full = longint'(v) * longint'(w);
    full = full >>> FRAC;
    return int'(full);
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mState = 0; mWeight = 0; mLast = 0; ptr = 0;
      foreach (mAcc[i]) mAcc[i] = 0;
      modelLive = 1'b1;
    end else begin
      if (startVertex && mState != 3) foreach (mAcc[i]) mAcc[i] = 0;
      case (mState)
        0: if (weightValid) begin
             mWeight = int'(weightData); mLast = weightLast; mState = 1;
           end
        1, 2: if (lineValid) begin
             int firstWord;
             if (mState == 1) begin
               posQ.delete();
               for (int p = 0; p < C; p++) if (lineData[p]) posQ.push_back(p);
               ptr = 0;
               firstWord = BMW;
             end else firstWord = 0;
             for (int wd = firstWord; wd < LN && ptr < posQ.size(); wd++) begin
               mAcc[posQ[ptr]] += scaled(int'(lineData[wd*DW +: DW]), mWeight);
               ptr++;
             end
             if (ptr < posQ.size()) mState = 2;
             else mState = mLast ? 3 : 0;
           end
        3: if (resReady) mState = 0;
        default: mState = 0;
      endcase
    end
  end

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (rstN && modelLive && !done) begin
      bit dataOk = 1'b1;
      int badSlot = 0;
      check(weightReady == (mState == 0), "R9 weightReady", longint'(weightReady), longint'(mState == 0));
      check(lineReady == (mState == 1 || mState == 2), "R9 lineReady", longint'(lineReady),
            longint'(mState == 1 || mState == 2));
      check(resValid == (mState == 3), "R7 resValid", longint'(resValid), longint'(mState == 3));
      for (int p = C - 1; p >= 0; p--) if (slotOf(p) != mAcc[p]) begin dataOk = 0; badSlot = p; end
      check(dataOk, "R3 slot data", longint'(slotOf(badSlot)), longint'(mAcc[badSlot]));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic pulseStart();
    startVertex = 1'b1;
    @(negedge clk);
    startVertex = 1'b0;
  endtask

  task automatic sendWeight(input int w, input bit last);
    weightData = DW'(w); weightLast = last; weightValid = 1'b1;
    while (!weightReady) @(negedge clk);
    @(negedge clk);
    weightValid = 1'b0;
  endtask

  task automatic sendLine(input logic [LN*DW-1:0] d);
    lineData = d; lineValid = 1'b1;
    while (!lineReady) @(negedge clk);
    @(negedge clk);
    lineValid = 1'b0;
  endtask

  // one neighbour: bitmap and values in position order; unused words filled with junk
  task automatic neighbour(input int w, input bit last, input logic [31:0] bmp,
                           input int vals[$], input string req);
    int k = 0;
    int nLines;
    logic [LN*DW-1:0] d;
    nLines = 1 + ((vals.size() > HEADV) ? (vals.size() - HEADV + LN - 1) / LN : 0);
    sendWeight(w, last);
    for (int ln = 0; ln < nLines; ln++) begin
      for (int wd = 0; wd < LN; wd++) d[wd*DW +: DW] = DW'(32'h5A5A0000 + wd * 7 + ln);
      if (ln == 0) d[DW-1:0] = bmp;
      for (int wd = (ln == 0) ? BMW : 0; wd < LN && k < vals.size(); wd++) begin
        d[wd*DW +: DW] = DW'(vals[k]); k++;
      end
      sendLine(d);
    end
    // no further line may be requested for this neighbour
    check(!lineReady, req, longint'(lineReady), 0);
  endtask

  task automatic waitResult(input int hold, input bit startWhileHeld);
    while (!resValid) @(negedge clk);
    for (int i = 0; i < hold; i++) begin
      if (startWhileHeld && i == 1) startVertex = 1'b1;
      @(negedge clk);
      startVertex = 1'b0;
      check(resValid, "R7 held valid", longint'(resValid), 1);
    end
  endtask

  task automatic releaseResult();
    resReady = 1'b1;
    @(negedge clk);
    resReady = 1'b0;
    check(weightReady, "R9 weight after result", longint'(weightReady), 1);
  endtask

  // ---------------- test sequence ----------------
  initial begin
    int q[$];
    repeat (3) @(negedge clk);
    check(!resValid && !lineReady && weightReady, "R1 reset flags",
          longint'({resValid, lineReady, weightReady}), 1);
    check(resData == '0, "R1 reset data", longint'(slotOf(0)), 0);
    rstN = 1'b1;
    @(negedge clk);

    // vertex 1: two sparse values, weight 2.0; start pulse while result pending
    pulseStart();
    q = '{256, -768};
    neighbour(512, 1'b1, 32'h0000_0005, q, "R5 single head line");
    waitResult(4, 1'b1);
    check(slotOf(0) == 512, "R3 slot0", slotOf(0), 512);
    check(slotOf(2) == -1536, "R3 slot2", slotOf(2), -1536);
    check(slotOf(1) == 0, "R4 zero bit untouched", slotOf(1), 0);
    check(slotOf(3) == 0, "R2 junk word ignored", slotOf(3), 0);
    check(slotOf(0) == 512, "R8 start ignored while pending", slotOf(0), 512);
    releaseResult();

    // vertex 2: full bitmap over three lines, empty neighbour, single-bit neighbour
    pulseStart();
    q.delete();
    for (int p = 0; p < C; p++) q.push_back((p + 1) * 256);
    neighbour(256, 1'b0, 32'hFFFF_FFFF, q, "R5 three lines for 32 ones");
    q.delete();
    neighbour(12345, 1'b0, 32'h0000_0000, q, "R6 empty bitmap one line");
    q = '{256};
    neighbour(256, 1'b1, 32'h8000_0000, q, "R5 last neighbour");
    waitResult(2, 1'b0);
    check(slotOf(10) == 2816, "R2 packed order slot10", slotOf(10), 2816);
    check(slotOf(15) == 4096, "R2 first body word slot15", slotOf(15), 4096);
    check(slotOf(31) == 8448, "R6 empty neighbour adds nothing", slotOf(31), 8448);
    releaseResult();

    // vertex 3: wrap-around
    pulseStart();
    q = '{32'h7FFF_FFFF};
    neighbour(256, 1'b0, 32'h0000_0020, q, "R5 wrap part one");
    neighbour(256, 1'b1, 32'h0000_0020, q, "R5 wrap part two");
    waitResult(1, 1'b0);
    check(slotOf(5) == -2, "R10 wrap", slotOf(5), -2);
    releaseResult();

    // vertex 4: clear coinciding with the head line, negative weight rounding down
    sendWeight(-384, 1'b1);
    lineData = '0;
    lineData[31:0] = 32'h0000_00A0;
    lineData[1*DW +: DW] = 32'd3;
    lineData[2*DW +: DW] = 32'd256;
    startVertex = 1'b1; lineValid = 1'b1;
    @(negedge clk);
    startVertex = 1'b0; lineValid = 1'b0;
    waitResult(1, 1'b0);
    check(slotOf(5) == -5, "R8 clear with line", slotOf(5), -5);
    check(slotOf(7) == -384, "R3 negative weight", slotOf(7), -384);
    releaseResult();

    // vertex 5: exactly 15 ones then exactly 16 ones
    pulseStart();
    q.delete();
    for (int p = 0; p < 15; p++) q.push_back(1);
    neighbour(256, 1'b0, 32'h0000_7FFF, q, "R5 fifteen ones one line");
    q.delete();
    for (int p = 0; p < 16; p++) q.push_back(2);
    neighbour(256, 1'b1, 32'h0000_FFFF, q, "R5 sixteen ones two lines");
    waitResult(1, 1'b0);
    check(slotOf(14) == 3, "R5 slot14", slotOf(14), 3);
    check(slotOf(15) == 2, "R5 slot15", slotOf(15), 2);
    check(slotOf(16) == 0, "R4 slot16", slotOf(16), 0);
    releaseResult();

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL R9 watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule